// File: doc/BRIEF.md
# Receive Path Supervisor

This block sits between a sampled 32-bit acquisition input and the write side of a receive FIFO. Each sample-clock enable offers one word. The word comes either from the live input, where it is taken only when its valid flag is set, or from an internal counter that the receive path can be tested with. The block writes accepted words into the FIFO and blocks any write while the FIFO reports full. It watches the full, half-full and empty flags and keeps a sticky record of overflow attempts and flag edges in one 8-bit control/status register. The bus side can read and write that register.

When an enabled status bit is set, the block raises an exception. Depending on a routing bit in the same register, the exception either pulls the active-low interrupt low or asks the bus controller to end the current transfer. A command bit in the register resets the FIFO for one clock and restarts the test counter.

Two small state machines run the block:
- **Flush machine.** `FL_RUN` moves to `FL_FLUSH` when a clear command is written. `FL_FLUSH` returns to `FL_RUN` after one clock.
- **Alarm machine.** It has the states `AL_QUIET`, `AL_IRQ` and `AL_ABORT`. `AL_QUIET` moves to `AL_IRQ` or `AL_ABORT` when an enabled status bit becomes pending, with the choice set by the routing bit. `AL_IRQ` and `AL_ABORT` swap when the routing bit changes while the exception is pending. Either one returns to `AL_QUIET` when no enabled status bit is pending.

Top module: `rxsup_top`

## Requirements
- R1: With bit 0 of the register clear (live mode), a clock with `smp_en` and `smp_valid` both high makes `fifo_wr` high for the following cycle, with `fifo_wdata` equal to `smp_data`. Without both, no write happens.
- R2: With bit 0 set (test mode), each `smp_en` clock offers the next value of a 32-bit counter that counts up from 0, and `smp_valid` is ignored. The counter advances on every such clock, including when the word is blocked.
- R3: An offered word is not written while `fifo_full` is high, and the attempt sets overflow status bit 2. Bit 2 stays set until a write with bit 2 high clears it. A new attempt in the same clock as that write wins, and the bit stays set.
- R4: A rising edge of `fifo_half` sets bit 3, and a rising edge of `fifo_empty` sets bit 4. Both bits are sticky and are cleared by writing 1 to them.
- R5: The register reads back as {0, half-enable, overflow-enable, bit4, bit3, bit2, route, test-select}. A write loads bits 0, 1, 5 and 6. Bits 2 to 4 are write-one-to-clear, and bit 7 always reads 0.
- R6: With route bit 1 clear, `irq_n` is low from the clock that sets an enabled status bit (bit 2 enabled by bit 5, bit 3 enabled by bit 6) until the clock that accepts the write clearing it. Bit 4 never raises an exception.
- R7: With route bit 1 set, the same exception drives `eot_req` high instead, and `irq_n` and `eot_req` are never active together.
- R8: Writing 1 to bit 7 drives `fifo_clr` high for exactly one cycle and resets the test counter to 0. No word is written in the command clock or in the clear cycle.
- R9: After reset the register reads 0, `irq_n` is high, and `eot_req`, `fifo_wr` and `fifo_clr` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_en | input | 1 | One-clock sample-clock enable |
| smp_valid | input | 1 | Live word valid |
| smp_data | input | 32 | Live data word |
| ctl_wr | input | 1 | Register write strobe |
| ctl_wdata | input | 8 | Register write data |
| ctl_rdata | output | 8 | Register read data |
| fifo_full | input | 1 | FIFO full flag |
| fifo_half | input | 1 | FIFO half-full flag |
| fifo_empty | input | 1 | FIFO empty flag |
| fifo_wr | output | 1 | FIFO write strobe |
| fifo_wdata | output | 32 | FIFO write data |
| fifo_clr | output | 1 | One-cycle FIFO reset |
| irq_n | output | 1 | Active-low interrupt |
| eot_req | output | 1 | End-of-transfer request to the bus controller |

## Verification
The bench offers words while the FIFO is full and confirms two things: the blocked word is lost, and the counter still advances past it. A design that stalled the counter would restart the sequence one value late. It clears the overflow bit in the same clock as a new overflow, so a design that let the clear win would read bit 2 back as 0. It holds `smp_en` high through the clear command and the clear cycle, which exposes a design that leaks a word into a FIFO being reset or keeps the old count. It also switches the routing bit and a disabled empty-edge status, which catches an interrupt raised on the wrong output or on a status bit that has no enable.

// File: rtl/rxsup_pkg.sv
package rxsup_pkg;
    localparam int CSR_W   = 8;
    localparam int B_TSEL  = 0;
    localparam int B_ROUTE = 1;
    localparam int B_OVF   = 2;
    localparam int B_HALF  = 3;
    localparam int B_EMPTY = 4;
    localparam int B_OVFEN = 5;
    localparam int B_HLFEN = 6;
    localparam int B_CLR   = 7;
    localparam int N_STAT  = 3;

    typedef enum logic {FL_RUN, FL_FLUSH} flush_e;
    typedef enum logic [1:0] {AL_QUIET, AL_IRQ, AL_ABORT} alarm_e;
endpackage

// File: rtl/rxsup_src.sv
module rxsup_src #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          smp_en,
    input  logic          smp_valid,
    input  logic [DW-1:0] smp_data,
    input  logic          test_sel,
    input  logic          run,
    input  logic          cnt_zero,
    input  logic          fifo_full,
    output logic          ovf_evt,
    output logic          fifo_wr,
    output logic [DW-1:0] fifo_wdata
);
    logic [DW-1:0] cnt_q;
    logic          offer;
    logic          accept;

    assign offer   = smp_en && (test_sel || smp_valid) && run;
    assign accept  = offer && !fifo_full;
    assign ovf_evt = offer && fifo_full;

    always_ff @(posedge clk) begin
        if (!rst_n || cnt_zero) begin
            cnt_q <= '0;
        end else if (run && test_sel && smp_en) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fifo_wr    <= 1'b0;
            fifo_wdata <= '0;
        end else begin
            fifo_wr <= accept;
            if (accept) begin
                fifo_wdata <= test_sel ? cnt_q : smp_data;
            end
        end
    end

    // R3: a write never follows a clock in which the FIFO was full
    assert_wr_not_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr |-> $past(!fifo_full));
endmodule

// File: rtl/rxsup_csr.sv
module rxsup_csr
    import rxsup_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [CSR_W-1:0] wdata,
    input  logic             ovf_evt,
    input  logic             fifo_half,
    input  logic             fifo_empty,
    output logic [CSR_W-1:0] rdata,
    output logic             test_sel,
    output logic             clr_cmd,
    output logic             pend_nxt,
    output logic             route_nxt,
    output logic             pend_q
);
    logic [N_STAT-1:0] st_q;
    logic [N_STAT-1:0] st_nxt;
    logic [N_STAT-1:0] evt;
    logic              half_prev_q, empty_prev_q;
    logic              tsel_q, route_q, ovfen_q, hlfen_q;
    logic              ovfen_nxt, hlfen_nxt;

    assign evt[0] = ovf_evt;
    assign evt[1] = fifo_half && !half_prev_q;
    assign evt[2] = fifo_empty && !empty_prev_q;

    for (genvar i = 0; i < N_STAT; i++) begin : g_stat
        assign st_nxt[i] = evt[i] || (st_q[i] && !(wr && wdata[B_OVF+i]));
        always_ff @(posedge clk) begin
            if (!rst_n) st_q[i] <= 1'b0;
            else        st_q[i] <= st_nxt[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            half_prev_q  <= 1'b0;
            empty_prev_q <= 1'b1;
            tsel_q       <= 1'b0;
            route_q      <= 1'b0;
            ovfen_q      <= 1'b0;
            hlfen_q      <= 1'b0;
        end else begin
            half_prev_q  <= fifo_half;
            empty_prev_q <= fifo_empty;
            if (wr) begin
                tsel_q  <= wdata[B_TSEL];
                route_q <= wdata[B_ROUTE];
                ovfen_q <= wdata[B_OVFEN];
                hlfen_q <= wdata[B_HLFEN];
            end
        end
    end

    assign ovfen_nxt = wr ? wdata[B_OVFEN] : ovfen_q;
    assign hlfen_nxt = wr ? wdata[B_HLFEN] : hlfen_q;
    assign route_nxt = wr ? wdata[B_ROUTE] : route_q;
    assign pend_nxt  = (st_nxt[0] && ovfen_nxt) || (st_nxt[1] && hlfen_nxt);
    assign pend_q    = (st_q[0] && ovfen_q) || (st_q[1] && hlfen_q);
    assign clr_cmd   = wr && wdata[B_CLR];
    assign test_sel  = tsel_q;
    assign rdata     = {1'b0, hlfen_q, ovfen_q, st_q, route_q, tsel_q};

    // R3: overflow status survives any clock without a clearing write
    assert_ovf_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q[0] && !(wr && wdata[B_OVF])) |=> st_q[0]);
    // R4: an empty-flag rising edge is recorded
    assert_empty_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_empty && !empty_prev_q) |=> st_q[2]);
endmodule

// File: rtl/rxsup_fsm.sv
module rxsup_fsm
    import rxsup_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr_cmd,
    input  logic pend_nxt,
    input  logic route_nxt,
    output logic run,
    output logic fifo_clr,
    output logic irq_n,
    output logic eot_req
);
    flush_e fl_q, fl_nxt;
    alarm_e al_q, al_nxt;

    always_comb begin
        fl_nxt = fl_q;
        unique case (fl_q)
            FL_RUN:   if (clr_cmd) fl_nxt = FL_FLUSH;
            FL_FLUSH: fl_nxt = FL_RUN;
            default:  fl_nxt = FL_RUN;
        endcase
    end

    always_comb begin
        al_nxt = al_q;
        unique case (al_q)
            AL_QUIET, AL_IRQ, AL_ABORT: begin
                if (!pend_nxt)      al_nxt = AL_QUIET;
                else if (route_nxt) al_nxt = AL_ABORT;
                else                al_nxt = AL_IRQ;
            end
            default: al_nxt = AL_QUIET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fl_q <= FL_RUN;
            al_q <= AL_QUIET;
        end else begin
            fl_q <= fl_nxt;
            al_q <= al_nxt;
        end
    end

    always_comb begin
        run      = (fl_q == FL_RUN) && !clr_cmd;
        fifo_clr = (fl_q == FL_FLUSH);
        irq_n    = (al_q != AL_IRQ);
        eot_req  = (al_q == AL_ABORT);
    end

    // R8: the FIFO reset pulse lasts exactly one cycle
    assert_clr_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_clr |=> !fifo_clr);
    // R7: interrupt and abort request are mutually exclusive
    assert_irq_eot_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(!irq_n && eot_req));
endmodule

// File: rtl/rxsup_top.sv
module rxsup_top
    import rxsup_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_en,
    input  logic             smp_valid,
    input  logic [DW-1:0]    smp_data,
    input  logic             ctl_wr,
    input  logic [CSR_W-1:0] ctl_wdata,
    output logic [CSR_W-1:0] ctl_rdata,
    input  logic             fifo_full,
    input  logic             fifo_half,
    input  logic             fifo_empty,
    output logic             fifo_wr,
    output logic [DW-1:0]    fifo_wdata,
    output logic             fifo_clr,
    output logic             irq_n,
    output logic             eot_req
);
    logic test_sel, clr_cmd, pend_nxt, route_nxt, pend_q, run, ovf_evt;

    rxsup_src #(.DW(DW)) u_src (
        .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .smp_valid(smp_valid),
        .smp_data(smp_data), .test_sel(test_sel), .run(run), .cnt_zero(clr_cmd),
        .fifo_full(fifo_full), .ovf_evt(ovf_evt), .fifo_wr(fifo_wr),
        .fifo_wdata(fifo_wdata)
    );

    rxsup_csr u_csr (
        .clk(clk), .rst_n(rst_n), .wr(ctl_wr), .wdata(ctl_wdata),
        .ovf_evt(ovf_evt), .fifo_half(fifo_half), .fifo_empty(fifo_empty),
        .rdata(ctl_rdata), .test_sel(test_sel), .clr_cmd(clr_cmd),
        .pend_nxt(pend_nxt), .route_nxt(route_nxt), .pend_q(pend_q)
    );

    rxsup_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .clr_cmd(clr_cmd), .pend_nxt(pend_nxt),
        .route_nxt(route_nxt), .run(run), .fifo_clr(fifo_clr),
        .irq_n(irq_n), .eot_req(eot_req)
    );

    // R6: an exception output is active exactly while an enabled status is set
    assert_alarm_tracks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q == (!irq_n || eot_req));
endmodule

// File: tb/sim_rxsup_top.sv
module sim_rxsup_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_en = 1'b0, smp_valid = 1'b0;
    logic [31:0] smp_data = '0;
    logic        ctl_wr = 1'b0;
    logic [7:0]  ctl_wdata = '0;
    logic [7:0]  ctl_rdata;
    logic        fifo_full = 1'b0, fifo_half = 1'b0, fifo_empty = 1'b1;
    logic        fifo_wr, fifo_clr, irq_n, eot_req;
    logic [31:0] fifo_wdata;
    int          checks = 0, errors = 0;
    bit          done = 0;

    always #2 clk = ~clk;

    rxsup_top u0 (
        .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .smp_valid(smp_valid),
        .smp_data(smp_data), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .ctl_rdata(ctl_rdata), .fifo_full(fifo_full), .fifo_half(fifo_half),
        .fifo_empty(fifo_empty), .fifo_wr(fifo_wr), .fifo_wdata(fifo_wdata),
        .fifo_clr(fifo_clr), .irq_n(irq_n), .eot_req(eot_req)
    );

    // {en, valid, full, data[31:0], exp_wr, exp_data[31:0]}
    localparam logic [67:0] VEC [0:7] = '{
        {3'b110, 32'hA5A5_0001, 1'b1, 32'hA5A5_0001},
        {3'b100, 32'h0000_1234, 1'b0, 32'h0},
        {3'b010, 32'h0000_5678, 1'b0, 32'h0},
        {3'b110, 32'hFFFF_FFFF, 1'b1, 32'hFFFF_FFFF},
        {3'b110, 32'h0000_0000, 1'b1, 32'h0000_0000},
        {3'b001, 32'h1111_1111, 1'b0, 32'h0},
        {3'b101, 32'h2222_2222, 1'b0, 32'h0},
        {3'b110, 32'hDEAD_BEEF, 1'b1, 32'hDEAD_BEEF}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        ctl_wr = 1'b0;
    endtask

    task automatic reg_write(input logic [7:0] v);
        ctl_wr = 1'b1;
        ctl_wdata = v;
        tick();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        // R9: reset state
        check("R9 rdata", 32'(ctl_rdata), 32'h00);
        check("R9 irq_n", 32'(irq_n), 32'h1);
        check("R9 eot_req", 32'(eot_req), 32'h0);
        check("R9 fifo_wr", 32'(fifo_wr), 32'h0);
        check("R9 fifo_clr", 32'(fifo_clr), 32'h0);

        // R1: live-mode vector table
        for (int i = 0; i < 8; i++) begin
            {smp_en, smp_valid, fifo_full, smp_data} = VEC[i][67:33];
            tick();
            check("R1 wr", 32'(fifo_wr), 32'(VEC[i][32]));
            if (VEC[i][32]) check("R1 data", fifo_wdata, VEC[i][31:0]);
        end
        smp_en = 0; smp_valid = 0; fifo_full = 0;
        check("R3 no overflow without offer", 32'(ctl_rdata), 32'h00);

        // R2: test counter, valid ignored
        reg_write(8'h01);
        smp_en = 1;
        for (int k = 0; k < 3; k++) begin
            tick();
            check("R2 wr", 32'(fifo_wr), 32'h1);
            check("R2 counter", fifo_wdata, 32'(k));
        end
        smp_en = 0;

        // R3/R6: overflow raises interrupt, sticky after drain
        reg_write(8'h21);
        fifo_full = 1; smp_en = 1;
        tick();
        check("R3 blocked", 32'(fifo_wr), 32'h0);
        check("R3 ovf bit", 32'(ctl_rdata), 32'h25);
        check("R6 irq low", 32'(irq_n), 32'h0);
        fifo_full = 0; smp_en = 0;
        tick();
        check("R3 sticky", 32'(ctl_rdata), 32'h25);
        check("R6 irq held", 32'(irq_n), 32'h0);
        smp_en = 1;
        tick();
        check("R2 count past lost word", fifo_wdata, 32'h4);
        smp_en = 0;
        reg_write(8'h25);
        check("R6 irq released", 32'(irq_n), 32'h1);
        check("R5 w1c", 32'(ctl_rdata), 32'h21);

        // R7: routed to abort
        reg_write(8'h23);
        fifo_full = 1; smp_en = 1;
        tick();
        fifo_full = 0; smp_en = 0;
        check("R7 eot", 32'(eot_req), 32'h1);
        check("R7 irq idle", 32'(irq_n), 32'h1);
        reg_write(8'h27);
        check("R7 eot released", 32'(eot_req), 32'h0);
        check("R5 readback", 32'(ctl_rdata), 32'h23);

        // R4/R6: half-full edge with enable
        reg_write(8'h41);
        fifo_half = 1;
        tick();
        fifo_half = 0;
        tick();
        check("R4 half bit", 32'(ctl_rdata), 32'h49);
        check("R6 half irq", 32'(irq_n), 32'h0);
        reg_write(8'h49);
        check("R6 half released", 32'(irq_n), 32'h1);

        // R4/R6: empty edge recorded, never raises exception
        fifo_empty = 0;
        tick();
        fifo_empty = 1;
        tick();
        check("R4 empty bit", 32'(ctl_rdata), 32'h51);
        check("R6 empty no irq", 32'(irq_n), 32'h1);
        reg_write(8'h51);
        check("R4 empty cleared", 32'(ctl_rdata), 32'h41);

        // R3: new overflow beats a same-clock clear
        fifo_full = 1; smp_en = 1;
        ctl_wr = 1; ctl_wdata = 8'h05;
        tick();
        fifo_full = 0; smp_en = 0;
        check("R3 set wins", 32'(ctl_rdata), 32'h05);
        reg_write(8'h05);
        check("R3 cleared", 32'(ctl_rdata), 32'h01);

        // R8: clear command
        smp_en = 1;
        ctl_wr = 1; ctl_wdata = 8'h81;
        tick();
        check("R8 clr high", 32'(fifo_clr), 32'h1);
        check("R8 no write on command", 32'(fifo_wr), 32'h0);
        check("R5 bit7 reads 0", 32'(ctl_rdata), 32'h01);
        tick();
        check("R8 clr one cycle", 32'(fifo_clr), 32'h0);
        check("R8 no write in clear", 32'(fifo_wr), 32'h0);
        tick();
        check("R8 counter restart wr", 32'(fifo_wr), 32'h1);
        check("R8 counter restart", fifo_wdata, 32'h0);
        tick();
        check("R8 counter next", fifo_wdata, 32'h1);
        smp_en = 0;

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule